// File: doc/BRIEF.md
# Linear Chirp Frequency Synthesizer

This block is a numerically controlled oscillator whose frequency ramps in a straight line. It holds two accumulators. The first is the frequency word. While sweeping is enabled, it moves by a programmable rate on every clock. The second is the phase register. It adds the current frequency word on every clock and wraps at its full width. The output frequency is therefore `freq_word * f_clk / 2^PHASE_W`, and it changes by a fixed amount each cycle.

The square-wave output is the top bit of the phase register. The upper phase bits are also brought out, so that a later stage can turn phase into any waveshape. A typical use is a step clock for a motor that must speed up and slow down smoothly.

The frequency word stays between two programmable bounds and never wraps. A one-cycle `done` pulse marks the moment it reaches the bound it is heading towards. When sweeping is disabled, the frequency stays fixed and the phase keeps running.

Top module: `chirp_dds`

## Requirements
- R1: A synchronous reset clears the phase register, loads `freq_word` with `start_inc`, and clears `done`.
- R2: On every clock edge out of reset, whether or not `run` is high, the phase register adds the `freq_word` value held before that edge. The sum wraps modulo 2^PHASE_W.
- R3: While `run` is high, each edge adds `rate` to `freq_word` when `sweep_down` is 0, and subtracts `rate` when `sweep_down` is 1.
- R4: `sq_out` equals bit PHASE_W-1 of the phase register. `phase_word` equals its top OUT_W bits.
- R5: While `run` is low, `freq_word` keeps its value.
- R6: In an upward sweep, a result at or above `lim_hi`, or one that overflows, is replaced by `lim_hi`.
- R7: In a downward sweep, a result at or below `lim_lo`, or one that borrows past zero, is replaced by `lim_lo`.
- R8: `done` is high for exactly the one cycle after the edge on which `freq_word` moves onto the bound of the current direction from a different value.
- R9: A new `rate` or `sweep_down` value present before an edge is used at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Enables the frequency sweep |
| sweep_down | input | 1 | 0 sweeps up, 1 sweeps down |
| start_inc | input | INC_W | Frequency word loaded at reset |
| lim_hi | input | INC_W | Upper frequency bound |
| lim_lo | input | INC_W | Lower frequency bound |
| rate | input | RATE_W | Unsigned sweep step per clock |
| sq_out | output | 1 | Square wave, phase MSB |
| phase_word | output | OUT_W | Top phase bits for waveshaping |
| freq_word | output | INC_W | Current frequency word |
| done | output | 1 | One-cycle pulse on reaching a bound |

## Verification
All results are registered directly, so every result is due one clock edge after the inputs that cause it. `freq_word`, the bound clamp and `done` all update on the same edge that samples `run`, `rate` and `sweep_down`. `phase_word` and `sq_out` show the sum formed from the frequency word held before that edge, so when a sweep is active the phase lags the frequency by one step. The bench changes inputs and samples outputs on falling edges. It counts whole cycles between each stimulus and the read that checks it, so every expected value belongs to a known edge.

// File: rtl/chirp_dds.sv
module chirp_dds #(
  parameter int PHASE_W = 32,
  parameter int INC_W   = 32,
  parameter int RATE_W  = 32,
  parameter int OUT_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              sweep_down,
  input  logic [INC_W-1:0]  start_inc,
  input  logic [INC_W-1:0]  lim_hi,
  input  logic [INC_W-1:0]  lim_lo,
  input  logic [RATE_W-1:0] rate,
  output logic              sq_out,
  output logic [OUT_W-1:0]  phase_word,
  output logic [INC_W-1:0]  freq_word,
  output logic              done
);
  localparam int EXT = INC_W + 1 - RATE_W;

  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] inc_ext;
  logic [INC_W-1:0]   inc_q;
  logic [INC_W:0]     rate_ext;
  logic [INC_W:0]     up_sum;
  logic [INC_W:0]     dn_diff;
  logic [INC_W-1:0]   up_next;
  logic [INC_W-1:0]   dn_next;
  logic [INC_W-1:0]   step_next;
  logic [INC_W-1:0]   bound;
  logic               hit;

  generate
    if (PHASE_W == INC_W) begin : g_same
      assign inc_ext = inc_q;
    end else begin : g_wide
      assign inc_ext = {{(PHASE_W-INC_W){1'b0}}, inc_q};
    end
  endgenerate

  assign rate_ext = {{EXT{1'b0}}, rate};
  assign up_sum   = {1'b0, inc_q} + rate_ext;
  assign dn_diff  = {1'b0, inc_q} - rate_ext;

  assign up_next = (up_sum >= {1'b0, lim_hi}) ? lim_hi : up_sum[INC_W-1:0];
  assign dn_next = (dn_diff[INC_W] || (dn_diff[INC_W-1:0] <= lim_lo)) ? lim_lo : dn_diff[INC_W-1:0];

  assign step_next = sweep_down ? dn_next : up_next;
  assign bound     = sweep_down ? lim_lo : lim_hi;
  assign hit       = run && (step_next == bound) && (inc_q != bound);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      inc_q   <= start_inc;
      done    <= 1'b0;
    end else begin
      phase_q <= phase_q + inc_ext;
      done    <= hit;
      if (run) inc_q <= step_next;
    end
  end

  assign sq_out     = phase_q[PHASE_W-1];
  assign phase_word = phase_q[PHASE_W-1 -: OUT_W];
  assign freq_word  = inc_q;
endmodule

// File: rtl/chirp_dds_chk.sv
module chirp_dds_chk #(
  parameter int PHASE_W = 32,
  parameter int INC_W   = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               run,
  input logic               sweep_down,
  input logic [INC_W-1:0]   lim_hi,
  input logic [INC_W-1:0]   lim_lo,
  input logic [PHASE_W-1:0] phase,
  input logic [INC_W-1:0]   inc,
  input logic               done
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst)) |-> (phase == $past(phase) + PHASE_W'($past(inc))));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst) && !$past(run)) |-> (inc == $past(inc)));

  p_up_cap_r6: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst) && $past(run) && !$past(sweep_down)) |-> (inc <= $past(lim_hi)));

  p_dn_floor_r7: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst) && $past(run) && $past(sweep_down)) |-> (inc >= $past(lim_lo)));

  p_done_at_bound_r8: assert property (@(posedge clk) disable iff (rst)
    (armed && done) |-> (inc == ($past(sweep_down) ? $past(lim_lo) : $past(lim_hi))));
endmodule

bind chirp_dds chirp_dds_chk #(.PHASE_W(PHASE_W), .INC_W(INC_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .sweep_down(sweep_down),
  .lim_hi(lim_hi), .lim_lo(lim_lo), .phase(phase_q), .inc(inc_q), .done(done)
);

// File: tb/sim_chirp_dds.sv
module sim_chirp_dds;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic        run = 1'b0;
  logic        sweep_down = 1'b0;
  logic [31:0] start_inc = '0;
  logic [31:0] lim_hi = '1;
  logic [31:0] lim_lo = '0;
  logic [31:0] rate = '0;
  logic        sq_out;
  logic [7:0]  phase_word;
  logic [31:0] freq_word;
  logic        done;

  int checks = 0;
  int errors = 0;

  chirp_dds u0 (
    .clk(clk), .rst(rst), .run(run), .sweep_down(sweep_down),
    .start_inc(start_inc), .lim_hi(lim_hi), .lim_lo(lim_lo), .rate(rate),
    .sq_out(sq_out), .phase_word(phase_word), .freq_word(freq_word), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic restart(input logic [31:0] s, input logic [31:0] r, input logic [31:0] hi,
                         input logic [31:0] lo, input logic dn, input logic en);
    rst = 1'b1; start_inc = s; rate = r; lim_hi = hi; lim_lo = lo; sweep_down = dn; run = en;
    tick(1);
    rst = 1'b0;
  endtask

  task automatic t_reset;
    restart(32'h0100_0000, 32'h10, '1, '0, 1'b0, 1'b0);
    check("R1 freq", freq_word, 32'h0100_0000);
    check("R1 phase", {24'h0, phase_word}, 32'h0);
    check("R1 done", {31'h0, done}, 32'h0);
  endtask

  task automatic t_hold;
    restart(32'h0100_0000, 32'h10, '1, '0, 1'b0, 1'b0);
    tick(5);
    check("R5 freq held", freq_word, 32'h0100_0000);
    check("R2 phase runs while held", {24'h0, phase_word}, 32'h05);
  endtask

  task automatic t_square;
    restart(32'h4000_0000, 32'h0, '1, '0, 1'b0, 1'b0);
    tick(1);
    check("R4 pw q1", {24'h0, phase_word}, 32'h40);
    check("R4 sq q1", {31'h0, sq_out}, 32'h0);
    tick(1);
    check("R4 sq q2", {31'h0, sq_out}, 32'h1);
    tick(1);
    check("R4 pw q3", {24'h0, phase_word}, 32'hC0);
    tick(1);
    check("R2 wrap", {24'h0, phase_word}, 32'h00);
    check("R4 sq wrap", {31'h0, sq_out}, 32'h0);
  endtask

  task automatic t_sweep_phase;
    restart(32'h1000_0000, 32'h1000_0000, 32'hF000_0000, '0, 1'b0, 1'b1);
    tick(1);
    check("R3 freq step", freq_word, 32'h2000_0000);
    check("R2 phase uses old freq", {24'h0, phase_word}, 32'h10);
    tick(2);
    check("R2 phase integrates ramp", {24'h0, phase_word}, 32'h60);
  endtask

  task automatic t_up_clamp;
    restart(32'h100, 32'h10, 32'h148, 32'h0, 1'b0, 1'b1);
    tick(2);
    check("R3 up ramp", freq_word, 32'h120);
    tick(2);
    check("R3 up ramp 4", freq_word, 32'h140);
    check("R8 no early done", {31'h0, done}, 32'h0);
    tick(1);
    check("R6 clamp hi", freq_word, 32'h148);
    check("R8 done pulse", {31'h0, done}, 32'h1);
    tick(1);
    check("R6 stays hi", freq_word, 32'h148);
    check("R8 done one cycle", {31'h0, done}, 32'h0);
    restart(32'hFFFF_FFF0, 32'h40, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b1);
    tick(1);
    check("R6 overflow clamps", freq_word, 32'hFFFF_FFFF);
  endtask

  task automatic t_down_clamp;
    restart(32'h200, 32'h40, 32'hFFFF, 32'h100, 1'b1, 1'b1);
    tick(3);
    check("R3 down ramp", freq_word, 32'h140);
    tick(1);
    check("R7 clamp lo", freq_word, 32'h100);
    check("R8 done down", {31'h0, done}, 32'h1);
    tick(2);
    check("R7 stays lo", freq_word, 32'h100);
    check("R8 done cleared", {31'h0, done}, 32'h0);
    restart(32'h30, 32'h40, 32'hFFFF, 32'h10, 1'b1, 1'b1);
    tick(1);
    check("R7 borrow clamps", freq_word, 32'h10);
  endtask

  task automatic t_change;
    restart(32'h100, 32'h10, 32'h1000, 32'h0, 1'b0, 1'b1);
    tick(1);
    check("R9 before change", freq_word, 32'h110);
    sweep_down = 1'b1;
    tick(1);
    check("R9 direction next edge", freq_word, 32'h100);
    rate = 32'h20;
    tick(1);
    check("R9 rate next edge", freq_word, 32'hE0);
    run = 1'b0;
    tick(3);
    check("R5 stop holds", freq_word, 32'hE0);
  endtask

  initial begin
    tick(1);
    t_reset();
    t_hold();
    t_square();
    t_sweep_phase();
    t_up_clamp();
    t_down_clamp();
    t_change();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule